// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, one frame at a time, whether a received Ethernet frame should be kept. For each request it looks at the 48-bit destination address, the frame's EtherType and its 12-bit VLAN identifier. It returns a single accept flag one clock later. The acceptance rules come from three tables held inside the block. The first is a set of exact-match station addresses, each gated by its own valid bit. The second is a 4096-bit multicast hash bitmap, indexed by a 12-bit window taken from the last two address bytes. The third is a 4096-bit VLAN membership bitmap. A programmable tag EtherType decides whether a frame counts as VLAN-tagged.

The tables are loaded through a plain single-cycle write port. A 2-bit selector picks the table, an address picks the word, and 32 data bits are written. Static control inputs set the policy:
- accept every broadcast frame;
- accept every multicast frame;
- accept every unicast frame;
- enable the VLAN check;
- choose one of four hash window positions.

A small two-state controller sequences the reply. `ST_IDLE` moves to `ST_REPLY` when a request arrives, and stays in `ST_IDLE` otherwise. `ST_REPLY` stays in `ST_REPLY` on a back-to-back request, and returns to `ST_IDLE` when no request is present.

Top module: `rx_addr_filter`

## Requirements
- R1: A request presented with `req_valid` high produces `rsp_valid` high on the next cycle, carrying that request's decision on `rsp_accept`. A cycle without a request is followed by `rsp_valid` low. `rsp_accept` is never high while `rsp_valid` is low. After reset both outputs are low.
- R2: Address classes are decided as follows, with address byte k at `req_dest[8k+7:8k]`:
  - broadcast: all 48 bits are one;
  - multicast: bit 0 of byte 0 (`req_dest[0]`) is set and the address is not broadcast;
  - unicast: anything else.
- R3: The address check passes at once for a broadcast address when `cfg_bcast_accept` is high. It passes at once for a multicast address when `cfg_mcast_all` is high, and for a unicast address when `cfg_ucast_all` is high.
- R4: Station table writes use `wr_sel`=0. `wr_addr[4:1]` selects one of 16 entries, and `wr_addr[0]`=1 selects the high word.
  - The low word holds bytes 0–3 (`req_dest[31:0]`).
  - The high word holds bytes 4–5 in bits 15:0 and the valid flag in bit 31. Bits 30:16 are ignored.
  - A valid entry equal to all six bytes passes the address check. An entry with a clear valid flag never matches.
- R5: If no earlier rule passes, the hash index is formed from `{byte5,byte4}` (`req_dest[47:32]`). That value is shifted right by 4, 3, 2 or 0 for `cfg_hash_mode` 0, 1, 2 or 3, and the low 12 bits are kept. The hash table is written with `wr_sel`=1 at word address index[11:5]. Bit index[4:0] of that word passes the check when set; otherwise the address check fails.
- R6: The VLAN table is written with `wr_sel`=2. When `cfg_vlan_en` is high and the frame is tagged, bit `req_vid[4:0]` of word `req_vid[11:5]` must be set, or the frame is rejected. When `cfg_vlan_en` is low, or the frame is untagged, the VLAN table has no effect.
- R7: A frame is tagged exactly when `req_ethertype` equals the tag type register. That register is written with `wr_sel`=3 from `wr_data[15:0]`.
- R8: A frame is accepted only when both the address check and the VLAN check pass.
- R9: A table write takes effect from the next cycle. A request in the same cycle as a write is judged on the old contents.
- R10: Reset clears all tables and the tag type register to zero. With no writes and no promiscuous flag, frames are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 2 | Table select: 0 station, 1 hash, 2 VLAN, 3 tag type |
| wr_addr | input | 7 | Word address within the selected table |
| wr_data | input | 32 | Write data |
| cfg_bcast_accept | input | 1 | Accept all broadcast frames |
| cfg_mcast_all | input | 1 | Accept all multicast frames |
| cfg_ucast_all | input | 1 | Accept all unicast frames |
| cfg_vlan_en | input | 1 | Enable VLAN membership check |
| cfg_hash_mode | input | 2 | Hash window position |
| req_valid | input | 1 | Request strobe |
| req_dest | input | 48 | Destination address, byte 0 in bits 7:0 |
| req_ethertype | input | 16 | Frame EtherType as read big-endian |
| req_vid | input | 12 | VLAN identifier |
| rsp_valid | output | 1 | Decision valid, one cycle after the request |
| rsp_accept | output | 1 | Frame accepted |

## Verification
The bench sweeps all four hash window positions over many addresses against a patterned hash table. A wrong shift amount or a swapped byte order would then pick the wrong bit and flip decisions. It probes the station table with an invalid entry that holds a matching address, and with an entry carrying junk in its unused high bits. A design that ignored the valid flag, or compared too many bits, would misjudge these. It drives a broadcast address with the broadcast flag off, which must fall through to the hash lookup, and checks that an address with bit 0 clear is not treated as multicast. Finally it writes a hash bit in the same cycle as a request, where a design forwarding write data would accept one cycle too early, and sweeps VLAN IDs with the check on and off, tagged and untagged.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        TBL_STATION = 2'd0,
        TBL_HASH    = 2'd1,
        TBL_VLAN    = 2'd2,
        TBL_TAGTYPE = 2'd3
    } tbl_sel_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_REPLY = 1'b1
    } fsm_e;

    // Right-shift amount for the hash window position
    function automatic logic [3:0] hash_shift(input logic [1:0] mode);
        logic [3:0] sh;
        unique case (mode)
            2'd0: sh = 4'd4;
            2'd1: sh = 4'd3;
            2'd2: sh = 4'd2;
            2'd3: sh = 4'd0;
        endcase
        return sh;
    endfunction

endpackage

// File: rtl/rxf_bitmap.sv
module rxf_bitmap #(
    parameter int IDX_W = 12,
    parameter int BIT_W = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-BIT_W-1:0] wr_word,
    input  logic [(1<<BIT_W)-1:0]  wr_data,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic                   rd_bit
);
    localparam int WORDS  = 1 << (IDX_W - BIT_W);
    localparam int WORD_W = 1 << BIT_W;

    logic [WORD_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_word] <= wr_data;
        end
    end

    assign rd_bit = mem[rd_idx[IDX_W-1:BIT_W]][rd_idx[BIT_W-1:0]];

endmodule

// File: rtl/rxf_station_cam.sv
module rxf_station_cam #(
    parameter int ENTRIES = 16,
    parameter int ENT_AW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ENT_AW-1:0] wr_entry,
    input  logic              wr_hi,
    input  logic [31:0]       wr_data,
    input  logic [47:0]       key,
    output logic              hit
);
    logic [31:0]        lo_q [ENTRIES];
    logic [31:0]        hi_q [ENTRIES];
    logic [ENTRIES-1:0] match;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                lo_q[i] <= '0;
                hi_q[i] <= '0;
            end
        end else if (wr_en) begin
            if (wr_hi) hi_q[wr_entry] <= wr_data;
            else       lo_q[wr_entry] <= wr_data;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        // bit 31 of the high word gates the entry
        assign match[g] = hi_q[g][31]
                        && (lo_q[g] == key[31:0])
                        && (hi_q[g][15:0] == key[47:32]);
    end

    assign hit = |match;

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
    parameter int NUM_STATIONS = 16,
    parameter int IDX_W        = 12,
    parameter int WORD_W       = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [6:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        cfg_bcast_accept,
    input  logic        cfg_mcast_all,
    input  logic        cfg_ucast_all,
    input  logic        cfg_vlan_en,
    input  logic [1:0]  cfg_hash_mode,
    input  logic        req_valid,
    input  logic [47:0] req_dest,
    input  logic [15:0] req_ethertype,
    input  logic [11:0] req_vid,
    output logic        rsp_valid,
    output logic        rsp_accept
);
    import rxf_pkg::*;

    localparam int BIT_W   = $clog2(WORD_W);
    localparam int WORD_AW = IDX_W - BIT_W;
    localparam int ENT_AW  = $clog2(NUM_STATIONS);

    tbl_sel_e sel_w;
    assign sel_w = tbl_sel_e'(wr_sel);

    // ---------------- table storage ----------------
    logic        station_hit_w;
    logic        hash_bit_w;
    logic        vlan_bit_w;
    logic [15:0] tag_type_q;
    logic [15:0] hash_win_w;
    logic [IDX_W-1:0] hash_idx_w;

    rxf_station_cam #(.ENTRIES(NUM_STATIONS), .ENT_AW(ENT_AW)) station_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en && sel_w == TBL_STATION),
        .wr_entry (wr_addr[ENT_AW:1]),
        .wr_hi    (wr_addr[0]),
        .wr_data  (wr_data),
        .key      (req_dest),
        .hit      (station_hit_w)
    );

    assign hash_win_w = req_dest[47:32] >> hash_shift(cfg_hash_mode);
    assign hash_idx_w = hash_win_w[IDX_W-1:0];

    rxf_bitmap #(.IDX_W(IDX_W), .BIT_W(BIT_W)) hash_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en && sel_w == TBL_HASH),
        .wr_word (wr_addr[WORD_AW-1:0]),
        .wr_data (wr_data[WORD_W-1:0]),
        .rd_idx  (hash_idx_w),
        .rd_bit  (hash_bit_w)
    );

    rxf_bitmap #(.IDX_W(IDX_W), .BIT_W(BIT_W)) vlan_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en && sel_w == TBL_VLAN),
        .wr_word (wr_addr[WORD_AW-1:0]),
        .wr_data (wr_data[WORD_W-1:0]),
        .rd_idx  (req_vid[IDX_W-1:0]),
        .rd_bit  (vlan_bit_w)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                             tag_type_q <= '0;
        else if (wr_en && sel_w == TBL_TAGTYPE) tag_type_q <= wr_data[15:0];
    end

    logic unused_sink;
    assign unused_sink = ^{wr_data, wr_addr, hash_win_w};

    // ---------------- decision ----------------
    logic is_bcast_w, is_mcast_w, is_ucast_w;
    logic promisc_w, addr_ok_w, tagged_w, vlan_check_w, vlan_ok_w, decide_w;

    assign is_bcast_w   = &req_dest;
    assign is_mcast_w   = req_dest[0] && !is_bcast_w;
    assign is_ucast_w   = !req_dest[0];
    assign promisc_w    = (is_bcast_w && cfg_bcast_accept)
                        || (is_mcast_w && cfg_mcast_all)
                        || (is_ucast_w && cfg_ucast_all);
    assign addr_ok_w    = promisc_w || station_hit_w || hash_bit_w;
    assign tagged_w     = (req_ethertype == tag_type_q);
    assign vlan_check_w = cfg_vlan_en && tagged_w;
    assign vlan_ok_w    = !vlan_check_w || vlan_bit_w;
    assign decide_w     = addr_ok_w && vlan_ok_w;

    // ---------------- reply controller ----------------
    fsm_e state_q, state_d;
    logic accept_q;

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = req_valid ? ST_REPLY : ST_IDLE;
            ST_REPLY: state_d = req_valid ? ST_REPLY : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            accept_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            accept_q <= req_valid && decide_w;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                rsp_valid  = 1'b0;
                rsp_accept = 1'b0;
            end
            ST_REPLY: begin
                rsp_valid  = 1'b1;
                rsp_accept = accept_q;
            end
        endcase
    end

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [47:0] req_dest,
    input logic        cfg_bcast_accept,
    input logic        cfg_ucast_all,
    input logic        cfg_mcast_all,
    input logic        station_hit,
    input logic        vlan_check,
    input logic        vlan_bit,
    input logic        rsp_valid,
    input logic        rsp_accept
);
    logic vlan_block;
    assign vlan_block = vlan_check && !vlan_bit;

    a_r1_reply_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r1_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r1_accept_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_accept);

    a_r3_bcast_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (&req_dest) && cfg_bcast_accept && !vlan_block) |=> rsp_accept);

    a_r3_ucast_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_dest[0] && cfg_ucast_all && !vlan_block) |=> rsp_accept);

    a_r3_mcast_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_dest[0] && !(&req_dest) && cfg_mcast_all && !vlan_block)
        |=> rsp_accept);

    a_r4_station_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && station_hit && !vlan_block) |=> rsp_accept);

    a_r8_vlan_block: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && vlan_block) |=> !rsp_accept);

endmodule

bind rx_addr_filter rxf_checker chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid        (req_valid),
    .req_dest         (req_dest),
    .cfg_bcast_accept (cfg_bcast_accept),
    .cfg_ucast_all    (cfg_ucast_all),
    .cfg_mcast_all    (cfg_mcast_all),
    .station_hit      (station_hit_w),
    .vlan_check       (vlan_check_w),
    .vlan_bit         (vlan_bit_w),
    .rsp_valid        (rsp_valid),
    .rsp_accept       (rsp_accept)
);

// File: tb/rx_addr_filter_tb_top.sv
`timescale 1ns/1ps
module rx_addr_filter_tb_top;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [6:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        c_b = 1'b0, c_m = 1'b0, c_u = 1'b0, c_v = 1'b0;
    logic [1:0]  c_mode = '0;
    logic        req_valid = 1'b0;
    logic [47:0] req_dest = '0;
    logic [15:0] req_et = 16'h0800;
    logic [11:0] req_vid = '0;
    logic        rsp_valid, rsp_accept;

    rx_addr_filter dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg_bcast_accept(c_b), .cfg_mcast_all(c_m), .cfg_ucast_all(c_u),
        .cfg_vlan_en(c_v), .cfg_hash_mode(c_mode),
        .req_valid(req_valid), .req_dest(req_dest), .req_ethertype(req_et),
        .req_vid(req_vid), .rsp_valid(rsp_valid), .rsp_accept(rsp_accept)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // shadow of what the bench has written
    logic [31:0] sh_lo [16];
    logic [31:0] sh_hi [16];
    logic [31:0] sh_hash [128];
    logic [31:0] sh_vlan [128];
    logic [15:0] sh_tag = '0;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    function automatic logic model(input logic [47:0] d, input logic [15:0] et,
                                   input logic [11:0] v);
        logic bc, mc, uc, ok;
        logic [15:0] win;
        logic [11:0] h;
        int sh;
        bc = &d;
        mc = d[0] && !bc;
        uc = !d[0];
        ok = (bc && c_b) || (mc && c_m) || (uc && c_u);
        for (int i = 0; i < 16; i++) begin
            if (sh_hi[i][31] && sh_lo[i] == d[31:0] && sh_hi[i][15:0] == d[47:32]) ok = 1'b1;
        end
        sh  = (c_mode == 2'd0) ? 4 : (c_mode == 2'd1) ? 3 : (c_mode == 2'd2) ? 2 : 0;
        win = d[47:32] >> sh;
        h   = win[11:0];
        if (sh_hash[h[11:5]][h[4:0]]) ok = 1'b1;
        if (c_v && et == sh_tag && !sh_vlan[v[11:5]][v[4:0]]) ok = 1'b0;
        return ok;
    endfunction

    task automatic shadow_wr(input logic [1:0] s, input logic [6:0] a, input logic [31:0] d);
        case (s)
            2'd0: if (a[0]) sh_hi[a[4:1]] = d; else sh_lo[a[4:1]] = d;
            2'd1: sh_hash[a] = d;
            2'd2: sh_vlan[a] = d;
            default: sh_tag = d[15:0];
        endcase
    endtask

    task automatic wr(input logic [1:0] s, input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        shadow_wr(s, a, d);
    endtask

    task automatic rq(input string tag, input logic [47:0] d, input logic [15:0] et,
                      input logic [11:0] v);
        logic e;
        @(negedge clk);
        req_valid = 1'b1; req_dest = d; req_et = et; req_vid = v;
        e = model(d, et, v);
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " rsp_valid"}, rsp_valid, 1'b1);
        chk(tag, rsp_accept, e);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin sh_lo[i] = '0; sh_hi[i] = '0; end
        for (int i = 0; i < 128; i++) begin sh_hash[i] = '0; sh_vlan[i] = '0; end

        repeat (3) @(negedge clk);
        chk("R1 reset rsp_valid", rsp_valid, 1'b0);
        chk("R1 reset rsp_accept", rsp_accept, 1'b0);
        rst_n = 1'b1;

        // R10: cleared tables reject everything non-promiscuous
        rq("R10 empty unicast", 48'h0000_1234_5678, 16'h0000, 12'd0);
        rq("R10 empty bcast", 48'hFFFF_FFFF_FFFF, 16'h0800, 12'd0);

        // R2/R3: class decoding against each promiscuous flag
        for (int f = 0; f < 8; f++) begin
            c_b = f[0]; c_m = f[1]; c_u = f[2];
            rq("R2 R3 bcast", 48'hFFFF_FFFF_FFFF, 16'h0800, 12'd0);
            rq("R2 R3 mcast", 48'h0000_005E_0001, 16'h0800, 12'd0);
            rq("R2 R3 ucast", 48'h2200_0000_0010, 16'h0800, 12'd0);
            rq("R2 R3 near-bcast", 48'hFFFF_FFFF_FFFE, 16'h0800, 12'd0);
        end
        c_b = 0; c_m = 0; c_u = 0;

        // R4: station entries
        wr(2'd0, 7'd6,  32'h4433_2210);
        wr(2'd0, 7'd7,  32'h8000_6655);
        wr(2'd0, 7'd10, 32'h0D0C_0B0A);
        wr(2'd0, 7'd11, 32'h0000_0F0E);
        wr(2'd0, 7'd30, 32'h7172_7374);
        wr(2'd0, 7'd31, 32'hFFFF_7576);
        rq("R4 valid entry match", 48'h6655_4433_2210, 16'h0800, 12'd0);
        rq("R4 invalid entry ignored", 48'h0F0E_0D0C_0B0A, 16'h0800, 12'd0);
        rq("R4 one byte off", 48'h6655_4433_2211, 16'h0800, 12'd0);
        rq("R4 upper byte off", 48'h6755_4433_2210, 16'h0800, 12'd0);
        rq("R4 junk high bits ignored", 48'h7576_7172_7374, 16'h0800, 12'd0);

        // R5: hash window sweep over all four modes
        for (int w = 0; w < 128; w++) begin
            wr(2'd1, 7'(w), 32'(w) * 32'h9E37_79B1 + 32'h0101_0101);
        end
        for (int md = 0; md < 4; md++) begin
            c_mode = 2'(md);
            for (int k = 0; k < 64; k++) begin
                rq("R5 hash lookup", {16'(k * 1237 + md * 5), 32'h3C3C_3C3C}, 16'h0800, 12'd0);
            end
            rq("R5 bcast falls to hash", 48'hFFFF_FFFF_FFFF, 16'h0800, 12'd0);
        end

        // R6/R7/R8: VLAN gating
        wr(2'd3, 7'd0, 32'hABCD_8100);
        for (int w = 0; w < 128; w++) begin
            wr(2'd2, 7'(w), 32'(w) * 32'h6C07_8965 ^ 32'h5555_0F0F);
        end
        for (int u = 0; u < 2; u++) begin
            c_u = u[0];
            for (int en = 0; en < 2; en++) begin
                c_v = en[0];
                for (int k = 0; k < 48; k++) begin
                    rq("R6 R8 tagged", {16'(k * 311), 32'h3C3C_3C3C}, 16'h8100, 12'(k * 37 + 5));
                    rq("R7 untagged", {16'(k * 311), 32'h3C3C_3C3C}, 16'h88A8, 12'(k * 37 + 5));
                end
            end
        end
        c_u = 0; c_v = 0;

        // R9: write and request in the same cycle
        c_mode = 2'd3;
        wr(2'd1, 7'd9, 32'h0000_0000);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd1; wr_addr = 7'd9; wr_data = 32'h0000_0008;
        req_valid = 1'b1; req_dest = 48'h0123_0000_0000; req_et = 16'h0800;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        chk("R9 same-cycle write sees old", rsp_accept, 1'b0);
        shadow_wr(2'd1, 7'd9, 32'h0000_0008);
        rq("R9 write visible next", 48'h0123_0000_0000, 16'h0800, 12'd0);

        // R1: gap and back-to-back
        @(negedge clk);
        chk("R1 idle gap", rsp_valid, 1'b0);
        req_valid = 1'b1; req_dest = 48'h0123_0000_0000;
        @(negedge clk);
        chk("R1 back-to-back first", rsp_accept, 1'b1);
        req_dest = 48'h0124_0000_0000;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 back-to-back valid", rsp_valid, 1'b1);
        chk("R1 back-to-back second", rsp_accept, model(48'h0124_0000_0000, 16'h0800, 12'd0));

        summary();
        $finish;
    end

endmodule